// File: doc/BRIEF.md
# Dithered Hybrid Digital Pulse-Width Modulator

This block turns a 10-bit duty command into one switch-control pulse in every switching period. It runs on a fast clock at 32 times the switching frequency. A 32-phase counter stands in for a tapped delay line. The upper five command bits give the coarse pulse width, counted in phases. The pulse starts at phase 0 and ends when the phase counter reaches the selected tap.

The lower five command bits drive a temporal dither. A frame counter counts completed periods, and its bit-reversed value is compared against the fine bits. A period gets one extra coarse step when that reversed value is below the fine value. Over any 32 consecutive periods the extra steps therefore add up to exactly the fine value, and they are spread evenly. This gives a 10-bit average resolution, and a steady command settles into a short repeating pattern instead of a limit cycle.

Two force inputs override the modulator for a whole period. The command and the force inputs are sampled only at the period boundary, so a period that has started always runs to its end unchanged.

Top module: `dpwm_hybrid`

## Requirements
- R1: One switching period lasts 32 clock cycles (phases 0 to 31). `frame_sync` is high in phase 0 and low in every other phase.
- R2: In a period of width W, `pwm_out` is high in phases 0 to W-1 and low in phases W to 31. The high part is one contiguous run that starts at phase 0.
- R3: When no force is active, W = C + D. C is `duty_cmd[9:5]` read as an unsigned number, and D is the dither bit from R4.
- R4: The n-th period boundary after reset (n = 0, 1, ...) uses the frame index k = n mod 32. D is 1 when the 5-bit reversal of k (bit 0 of k becomes bit 4) is less than F = `duty_cmd[4:0]`. Any 32 consecutive unforced periods with a constant command hold 32*C + F high cycles in total.
- R5: The inputs are sampled only on the clock edge that leaves phase 31, and that sample sets the width of the next period. Input changes during a period have no effect on that period.
- R6: A sampled `force_off` makes W = 0 (output low for the whole period). It wins over `force_on`.
- R7: A sampled `force_on` with `force_off` low makes W = 32 (output high for the whole period).
- R8: C = 0 with D = 0 gives no pulse. C = 31 with D = 1 saturates to W = 32, which is fully on.
- R9: While `rst_n` is low, `pwm_out` is low. The first period after reset has W = 0 and starts at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, 32 times the switching frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | 10 | Duty command: coarse tap in [9:5], dither fraction in [4:0] |
| force_on | input | 1 | Hold the output high for the next period |
| force_off | input | 1 | Hold the output low for the next period (wins over force_on) |
| pwm_out | output | 1 | Registered switch-control pulse |
| frame_sync | output | 1 | High in phase 0 of each period |

## Verification
The bench builds the block with its defaults: 5 coarse bits, 5 fine bits and dither enabled. That gives 32-cycle periods, so a full 32-period dither frame takes about a thousand cycles, and a run of several hundred random periods walks the frame index around many times. With these values the bench can reach both ends of the width range. It covers the saturating corner (coarse 31 plus a dither step) as well as the empty corner (coarse 0 with no step). It also sums the high cycles over complete dither frames, in addition to checking each period's shape phase by phase.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
   // Which source decides the width of a period
   typedef enum logic [1:0] {
      PK_MOD = 2'd0,
      PK_ON  = 2'd1,
      PK_OFF = 2'd2
   } period_kind_e;
endpackage

// File: rtl/dpwm_phase_gen.sv
module dpwm_phase_gen #(
   parameter int PHASE_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PHASE_W-1:0] phase,
   output logic               last_phase,
   output logic               frame_sync
);
   localparam logic [PHASE_W-1:0] LAST = {PHASE_W{1'b1}};

   logic [PHASE_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= '0;
      else        ph_q <= ph_q + 1'b1;
   end

   assign phase      = ph_q;
   assign last_phase = (ph_q == LAST);
   assign frame_sync = (ph_q == '0);

   // R1
   phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_phase |=> frame_sync);
   // R1
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !last_phase |=> !frame_sync);
endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither #(
   parameter int FINE_W    = 5,
   parameter bit DITHER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic [FINE_W-1:0] fine,
   output logic              inc
);
   generate
      if (DITHER_EN) begin : g_dither
         logic [FINE_W-1:0] frame_q;
         logic [FINE_W-1:0] frame_rev;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       frame_q <= '0;
            else if (advance) frame_q <= frame_q + 1'b1;
         end

         for (genvar b = 0; b < FINE_W; b++) begin : g_rev
            assign frame_rev[b] = frame_q[FINE_W-1-b];
         end

         assign inc = (frame_rev < fine);

         // R4
         dither_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fine == '0) |-> !inc);
         // R4
         frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !advance |=> $stable(frame_q));
      end else begin : g_plain
         assign inc = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dpwm_width_calc.sv
module dpwm_width_calc
   import dpwm_pkg::*;
#(
   parameter int COARSE_W = 5
) (
   input  logic [COARSE_W-1:0] coarse,
   input  logic                inc,
   input  logic                force_on,
   input  logic                force_off,
   output logic [COARSE_W:0]   width
);
   localparam logic [COARSE_W:0] FULL = (COARSE_W+1)'(1) << COARSE_W;

   period_kind_e      kind;
   logic [COARSE_W:0] sum;

   always_comb begin
      if (force_off)     kind = PK_OFF;
      else if (force_on) kind = PK_ON;
      else               kind = PK_MOD;
   end

   assign sum = {1'b0, coarse} + {{COARSE_W{1'b0}}, inc};

   always_comb begin
      case (kind)
         PK_OFF:  width = '0;
         PK_ON:   width = FULL;
         default: width = (sum > FULL) ? FULL : sum;
      endcase
   end
endmodule

// File: rtl/dpwm_pulse_out.sv
module dpwm_pulse_out #(
   parameter int COARSE_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [COARSE_W-1:0] phase,
   input  logic                last_phase,
   input  logic [COARSE_W:0]   next_width,
   output logic                pwm_out
);
   logic [COARSE_W:0]   width_q;
   logic [COARSE_W:0]   width_sel;
   logic [COARSE_W-1:0] phase_nxt;
   logic                pwm_q;

   assign phase_nxt = last_phase ? '0 : phase + 1'b1;
   assign width_sel = last_phase ? next_width : width_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q <= '0;
         pwm_q   <= 1'b0;
      end else begin
         width_q <= width_sel;
         pwm_q   <= ({1'b0, phase_nxt} < width_sel);
      end
   end

   assign pwm_out = pwm_q;

   // R5
   width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !last_phase |=> $stable(width_q));
   // R2
   pulse_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_q && !last_phase) |=> !pwm_q);
endmodule

// File: rtl/dpwm_hybrid.sv
module dpwm_hybrid #(
   parameter int COARSE_W  = 5,
   parameter int FINE_W    = 5,
   parameter bit DITHER_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [COARSE_W+FINE_W-1:0] duty_cmd,
   input  logic                       force_on,
   input  logic                       force_off,
   output logic                       pwm_out,
   output logic                       frame_sync
);
   localparam int CMD_W = COARSE_W + FINE_W;

   initial begin : param_chk
      assert (COARSE_W >= 1 && COARSE_W <= 10)
         else $error("COARSE_W out of range");
      assert (FINE_W >= 1 && FINE_W <= 10)
         else $error("FINE_W out of range");
   end

   logic [COARSE_W-1:0] phase;
   logic                last_phase;
   logic [COARSE_W-1:0] coarse;
   logic [FINE_W-1:0]   fine;
   logic                dith_inc;
   logic [COARSE_W:0]   next_width;

   assign coarse = duty_cmd[CMD_W-1:FINE_W];
   assign fine   = duty_cmd[FINE_W-1:0];

   dpwm_phase_gen #(.PHASE_W(COARSE_W)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .last_phase (last_phase),
      .frame_sync (frame_sync)
   );

   dpwm_dither #(.FINE_W(FINE_W), .DITHER_EN(DITHER_EN)) u_dither (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (last_phase),
      .fine    (fine),
      .inc     (dith_inc)
   );

   dpwm_width_calc #(.COARSE_W(COARSE_W)) u_width (
      .coarse    (coarse),
      .inc       (dith_inc),
      .force_on  (force_on),
      .force_off (force_off),
      .width     (next_width)
   );

   dpwm_pulse_out #(.COARSE_W(COARSE_W)) u_pulse (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .last_phase (last_phase),
      .next_width (next_width),
      .pwm_out    (pwm_out)
   );

   // R6
   force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_phase && force_off) |=> !pwm_out);
   // R7
   force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_phase && force_on && !force_off) |=> pwm_out);
   // R8
   empty_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_phase && !force_on && !force_off && coarse == '0 && !dith_inc)
      |=> !pwm_out);
   // R8
   sat_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_phase && !force_off && coarse == '1 && dith_inc) |=> pwm_out);
   // R9
   reset_low_chk: assert property (@(posedge clk)
      !rst_n |-> !pwm_out);
endmodule

// File: tb/dpwm_hybrid_tb.sv
module dpwm_hybrid_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [9:0] duty_cmd;
   logic       force_on;
   logic       force_off;
   logic       pwm_out;
   logic       frame_sync;

   always #5 clk = ~clk;

   dpwm_hybrid u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .duty_cmd   (duty_cmd),
      .force_on   (force_on),
      .force_off  (force_off),
      .pwm_out    (pwm_out),
      .frame_sync (frame_sync)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   int    bframe = 0;
   int    exp_cur = 0;
   int    last_high = 0;
   string tag_cur = "R9";
   bit    done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int bitrev5(input int k);
      int r = 0;
      for (int b = 0; b < 5; b++) if (k[b]) r |= (1 << (4 - b));
      return r;
   endfunction

   function automatic int exp_w(input logic [9:0] c, input bit on, input bit off, input int k);
      int d;
      if (off) return 0;
      if (on)  return 32;
      d = (bitrev5(k) < int'(c[4:0])) ? 1 : 0;
      return int'(c[9:5]) + d;
   endfunction

   // Called at the negedge of phase 0. The inputs given here set the next
   // period; the current period is observed against the earlier expectation.
   task automatic run_period(input logic [9:0] c, input bit on, input bit off,
                             input bit mid, input string req);
      int nxt, high, bad;
      duty_cmd  = mid ? ~c : c;
      force_on  = mid ? ~on : on;
      force_off = mid ? 1'b0 : off;
      nxt = exp_w(c, on, off, bframe);
      bframe = (bframe + 1) % 32;
      high = 0;
      bad = 0;
      for (int i = 0; i < 32; i++) begin
         if (pwm_out !== (i < exp_cur)) bad++;
         if (frame_sync !== (i == 0)) bad++;
         if (pwm_out === 1'b1) high++;
         if (mid && i == 16) begin
            duty_cmd  = c;
            force_on  = on;
            force_off = off;
         end
         @(negedge clk);
      end
      chk(bad == 0 && high == exp_cur, tag_cur, high, exp_cur);
      last_high = high;
      exp_cur = nxt;
      tag_cur = req;
   endtask

   initial begin : watchdog
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      int sum;
      logic [9:0] rc;
      bit ron, roff;
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0;
      duty_cmd = '0;
      force_on = 1'b0;
      force_off = 1'b0;
      repeat (3) @(negedge clk);
      chk(pwm_out === 1'b0, "R9", int'(pwm_out), 0);
      rst_n = 1'b1;
      chk(frame_sync === 1'b1, "R1", int'(frame_sync), 1);

      // R9: first period empty; R8: coarse 0 without dither step
      run_period(10'd0, 0, 0, 0, "R8");
      run_period(10'd0, 0, 0, 0, "R8");
      // R2: plain coarse widths
      run_period({5'd10, 5'd0}, 0, 0, 0, "R2");
      run_period({5'd1, 5'd0}, 0, 0, 0, "R2");
      run_period({5'd30, 5'd0}, 0, 0, 0, "R2");

      // R4: dither total over a full frame of 32 periods
      run_period({5'd7, 5'd5}, 0, 0, 0, "R3");
      sum = 0;
      for (int p = 0; p < 32; p++) begin
         run_period({5'd7, 5'd5}, 0, 0, 0, "R3");
         sum += last_high;
      end
      chk(sum == 32 * 7 + 5, "R4", sum, 32 * 7 + 5);

      // R4: half-frame fraction, every second period gets a step
      sum = 0;
      for (int p = 0; p < 32; p++) begin
         run_period({5'd3, 5'd16}, 0, 0, 0, "R4");
         if (p > 0) sum += last_high;
      end
      run_period({5'd3, 5'd16}, 0, 0, 0, "R4");
      sum += last_high;
      chk(sum == 32 * 3 + 16, "R4", sum, 32 * 3 + 16);

      // R8: saturation to fully on
      for (int p = 0; p < 33; p++) run_period({5'd31, 5'd31}, 0, 0, 0, "R8");

      // R7, R6: forces
      run_period({5'd4, 5'd0}, 1, 0, 0, "R7");
      run_period({5'd0, 5'd0}, 1, 0, 0, "R7");
      run_period({5'd31, 5'd31}, 0, 1, 0, "R6");
      run_period({5'd20, 5'd3}, 1, 1, 0, "R6");

      // R5: mid-period changes have no effect on the running period
      for (int p = 0; p < 6; p++) run_period({5'(p * 5), 5'(p * 3)}, 0, 0, 1, "R5");

      // R3: constrained random commands with occasional forces
      for (int p = 0; p < 250; p++) begin
         rc   = 10'($urandom);
         ron  = ($urandom % 8) == 0;
         roff = ($urandom % 10) == 0;
         run_period(rc, ron, roff, ($urandom % 5) == 0, "R3");
      end
      run_period(10'd0, 0, 0, 0, "R3");
      run_period(10'd0, 0, 0, 0, "R3");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule